// File: doc/BRIEF.md
# Whitened CRC-Protected FEC Frame Encoder

This block turns a short payload (zero to sixteen bytes) into the byte stream for one radio frame. Software or an upstream engine first fills a payload store through a byte-wide write port. A start strobe then latches the payload length, a scramble enable and a four-byte link address.

The block runs a hash pass over the payload, one byte per cycle. In that pass it optionally whitens each byte with a fixed key table and folds it into a 16-bit CRC. It then emits the frame on a valid/ready byte stream. The frame is made up of the address, a two-byte sync marker, and four line bytes for each payload or CRC byte. Each line byte carries two redundancy-coded bits, and every byte on the wire is bit-reversed.

The frame length is available on its own output from the moment start is accepted. A downstream radio FIFO loader can size its transfer from it.

Top module: `rfenc_top`

## Requirements
- R1: With `scramble_en` set at start, payload byte i is XORed with key[i] before the CRC and FEC stages. The key, for i = 0..15, is D0 9E 53 33 D8 BA 98 08 24 CB 3B FC 71 A3 F4 55. With it clear, payload bytes pass unchanged.
- R2: The CRC register is cleared to 0x0000 on start. It uses polynomial 0x1021, shifting MSB first, and each whitened payload byte is bit-reversed before it enters. Two bytes follow the payload: the reversed high CRC byte first, then the reversed low CRC byte.
- R3: With scrambling on, the two CRC bytes are further XORed with 0xAE (first byte) and 0xE4 (second byte).
- R4: Emission order is fixed. First come the address bytes, `tx_addr[7:0]` first and `tx_addr[31:24]` last. Then come two 0xC3 marker bytes. Then come four line bytes for each of the N payload bytes in index order, followed by the two CRC bytes.
- R5: `frame_len` equals 6 + 4*(N+2), where N is `pay_len` clamped to 16. It therefore ranges from 14 to 78, and it reads 14 after reset.
- R6: Each source byte is coded LSB first, two bits per line byte. A 1 bit maps to nibble 0xC and a 0 bit to nibble 0x3. The earlier bit takes the upper nibble, before the final reversal.
- R7: Every emitted byte is bit-reversed just before output, address and marker included. For example, an address byte 0x01 leaves as 0x80.
- R8: A byte is transferred when `out_valid` and `out_ready` are both high. While valid is high and ready is low, `out_data` holds. `out_valid` falls after the last byte of the frame is transferred.
- R9: A start strobe while `busy` is high is ignored. The running frame, its length and its address are unaffected.
- R10: Payload writes while `busy` is high are ignored, so the stored payload keeps its contents.
- R11: After reset `busy` and `out_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a frame (taken only while idle) |
| pay_len | input | 5 | Payload length N, values above 16 clamp to 16 |
| scramble_en | input | 1 | Enable key whitening and CRC mask |
| tx_addr | input | 32 | Link address, low byte sent first |
| wr_en | input | 1 | Payload store write enable |
| wr_idx | input | 4 | Payload store write index |
| wr_data | input | 8 | Payload store write data |
| busy | output | 1 | Frame in hash pass or emission |
| frame_len | output | 7 | Total frame length in bytes |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts byte |
| out_data | output | 8 | Output byte |

## Verification
The hardest situation to reach from the ports is a start strobe and a payload write arriving together in the middle of emission. The write must target a byte that has not yet been sent, or a lost lock would go unseen. The stimulus raises both on the fourth transfer of a 16-byte scrambled frame, with a different length and an inverted byte 0. The rest of the frame must still match the original reference. A restart afterwards with no new writes must reproduce the same frame. Back-pressure is exercised with alternating and one-in-three ready patterns, and every stalled cycle is checked for a held byte.

// File: rtl/rfenc_pkg.sv
package rfenc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HASH = 2'd1,
    ST_SEND = 2'd2
  } seq_state_e;

  localparam logic [7:0]  SYNC_BYTE    = 8'hC3;
  localparam logic [15:0] CRC_POLY     = 16'h1021;
  localparam logic [15:0] SCR_CRC_MASK = 16'hAEE4;

  function automatic logic [7:0] rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  function automatic logic [7:0] white_key(input logic [3:0] i);
    logic [7:0] k;
    case (i)
      4'd0:  k = 8'hD0;
      4'd1:  k = 8'h9E;
      4'd2:  k = 8'h53;
      4'd3:  k = 8'h33;
      4'd4:  k = 8'hD8;
      4'd5:  k = 8'hBA;
      4'd6:  k = 8'h98;
      4'd7:  k = 8'h08;
      4'd8:  k = 8'h24;
      4'd9:  k = 8'hCB;
      4'd10: k = 8'h3B;
      4'd11: k = 8'hFC;
      4'd12: k = 8'h71;
      4'd13: k = 8'hA3;
      4'd14: k = 8'hF4;
      default: k = 8'h55;
    endcase
    return k;
  endfunction

  // one byte into the CRC, MSB of d first
  function automatic logic [15:0] crc_step8(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    logic        fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[15] ^ d[i];
      r  = {r[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
    end
    return r;
  endfunction

  function automatic logic [3:0] fec_sym(input logic b);
    return b ? 4'hC : 4'h3;
  endfunction

endpackage

// File: rtl/rfenc_store.sv
module rfenc_store #(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lock,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_idx,
  output logic [7:0]    rd_data
);

  logic [7:0] mem_q [DEPTH];

  generate
    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
      logic ent_en;
      assign ent_en = wr_en && !lock && (wr_idx == AW'(e));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      mem_q[e] <= 8'h00;
        else if (ent_en) mem_q[e] <= wr_data;
      end

      // R10: a write attempted during a frame leaves the entry untouched
      p_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && wr_en && wr_idx == AW'(e)) |=> $stable(mem_q[e]));
    end
  endgenerate

  always_comb begin
    rd_data = 8'h00;
    for (int e = 0; e < DEPTH; e++)
      if (rd_idx == AW'(e)) rd_data = mem_q[e];
  end

endmodule

// File: rtl/rfenc_crc.sv
module rfenc_crc (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc_q
);
  import rfenc_pkg::*;

  logic [15:0] crc_d;
  logic        crc_ce;

  always_comb begin
    crc_ce = clr || en;
    crc_d  = clr ? 16'h0000 : crc_step8(crc_q, rev8(din));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= 16'h0000;
    else if (crc_ce) crc_q <= crc_d;
  end

endmodule

// File: rtl/rfenc_ctrl.sv
module rfenc_ctrl #(
  parameter int MAX_LEN    = 16,
  parameter int ADDR_BYTES = 4,
  parameter int LEN_W      = 5,
  parameter int IDX_W      = 7,
  parameter int AW         = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [LEN_W-1:0]        len_in,
  input  logic                    scr_in,
  input  logic [8*ADDR_BYTES-1:0] addr_in,
  input  logic                    out_ready,
  output logic                    busy,
  output logic                    out_valid,
  output logic                    hash_en,
  output logic                    crc_clr,
  output logic [LEN_W-1:0]        len_q,
  output logic                    scr_q,
  output logic [8*ADDR_BYTES-1:0] addr_q,
  output logic [IDX_W-1:0]        idx_q,
  output logic [IDX_W-1:0]        frame_len,
  output logic [AW-1:0]           rd_idx
);
  import rfenc_pkg::*;

  localparam int HDR_BYTES = ADDR_BYTES + 2;
  localparam int MAX_FRAME = HDR_BYTES + (MAX_LEN + 2) * 4;

  seq_state_e              state_q, state_d;
  logic [LEN_W-1:0]        len_d, ptr_q, ptr_d, len_clamp;
  logic                    scr_d;
  logic [8*ADDR_BYTES-1:0] addr_d;
  logic [IDX_W-1:0]        idx_d;

  assign frame_len = IDX_W'(HDR_BYTES) + ((IDX_W'(len_q) + IDX_W'(2)) << 2);
  assign busy      = (state_q != ST_IDLE);
  assign out_valid = (state_q == ST_SEND);
  assign hash_en   = (state_q == ST_HASH);
  assign crc_clr   = start && (state_q == ST_IDLE);
  assign len_clamp = (len_in > LEN_W'(MAX_LEN)) ? LEN_W'(MAX_LEN) : len_in;
  assign rd_idx    = hash_en ? AW'(ptr_q)
                             : AW'((idx_q - IDX_W'(HDR_BYTES)) >> 2);

  always_comb begin
    state_d = state_q;
    len_d   = len_q;
    scr_d   = scr_q;
    addr_d  = addr_q;
    ptr_d   = ptr_q;
    idx_d   = idx_q;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          len_d   = len_clamp;
          scr_d   = scr_in;
          addr_d  = addr_in;
          ptr_d   = '0;
          idx_d   = '0;
          state_d = (len_clamp == '0) ? ST_SEND : ST_HASH;
        end
      end
      ST_HASH: begin
        ptr_d = ptr_q + LEN_W'(1);
        if (ptr_q == len_q - LEN_W'(1)) state_d = ST_SEND;
      end
      ST_SEND: begin
        if (out_ready) begin
          if (idx_q == frame_len - IDX_W'(1)) state_d = ST_IDLE;
          else                                idx_d   = idx_q + IDX_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      len_q   <= '0;
      scr_q   <= 1'b0;
      addr_q  <= '0;
      ptr_q   <= '0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      len_q   <= len_d;
      scr_q   <= scr_d;
      addr_q  <= addr_d;
      ptr_q   <= ptr_d;
      idx_q   <= idx_d;
    end
  end

  // R9: start while busy changes nothing latched
  p_start_ign_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(len_q) && $stable(addr_q) && $stable(scr_q)));

  // R5: length stays in range and keeps its 4-byte granularity
  p_len_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_len <= IDX_W'(MAX_FRAME)) && (frame_len[1:0] == 2'b10));

endmodule

// File: rtl/rfenc_byte_map.sv
module rfenc_byte_map #(
  parameter int ADDR_BYTES = 4,
  parameter int LEN_W      = 5,
  parameter int IDX_W      = 7
) (
  input  logic [IDX_W-1:0]        idx,
  input  logic [LEN_W-1:0]        len_q,
  input  logic [8*ADDR_BYTES-1:0] addr_q,
  input  logic [15:0]             crc_q,
  input  logic                    scr_q,
  input  logic [7:0]              src_byte,
  output logic [7:0]              byte_out
);
  import rfenc_pkg::*;

  localparam int HDR_BYTES = ADDR_BYTES + 2;

  logic [IDX_W-1:0] k, src;
  logic [1:0]       q;
  logic [7:0]       crc_hi, crc_lo, pick, raw;
  logic [15:0]      mask;

  always_comb begin
    k      = idx - IDX_W'(HDR_BYTES);
    src    = {2'b00, k[IDX_W-1:2]};
    q      = k[1:0];
    mask   = scr_q ? SCR_CRC_MASK : 16'h0000;
    crc_hi = rev8(crc_q[15:8]) ^ mask[15:8];
    crc_lo = rev8(crc_q[7:0])  ^ mask[7:0];

    if (src < IDX_W'(len_q))       pick = src_byte;
    else if (src == IDX_W'(len_q)) pick = crc_hi;
    else                           pick = crc_lo;

    raw = {fec_sym(pick[{q, 1'b0}]), fec_sym(pick[{q, 1'b1}])};

    if (idx < IDX_W'(ADDR_BYTES)) begin
      raw = 8'h00;
      for (int a = 0; a < ADDR_BYTES; a++)
        if (idx == IDX_W'(a)) raw = addr_q[8*a +: 8];
    end else if (idx < IDX_W'(HDR_BYTES)) begin
      raw = SYNC_BYTE;
    end

    byte_out = rev8(raw);
  end

endmodule

// File: rtl/rfenc_top.sv
module rfenc_top #(
  parameter  int MAX_LEN    = 16,
  parameter  int ADDR_BYTES = 4,
  localparam int LEN_W      = $clog2(MAX_LEN + 1),
  localparam int AW         = $clog2(MAX_LEN),
  localparam int MAX_FRAME  = ADDR_BYTES + 2 + (MAX_LEN + 2) * 4,
  localparam int IDX_W      = $clog2(MAX_FRAME + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [LEN_W-1:0]        pay_len,
  input  logic                    scramble_en,
  input  logic [8*ADDR_BYTES-1:0] tx_addr,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_idx,
  input  logic [7:0]              wr_data,
  output logic                    busy,
  output logic [IDX_W-1:0]        frame_len,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [7:0]              out_data
);
  import rfenc_pkg::*;

  logic                    hash_en, crc_clr, scr_q;
  logic [LEN_W-1:0]        len_q;
  logic [8*ADDR_BYTES-1:0] addr_q;
  logic [IDX_W-1:0]        idx_q;
  logic [AW-1:0]           rd_idx;
  logic [7:0]              rd_data, white;
  logic [15:0]             crc_q;

  rfenc_ctrl #(
    .MAX_LEN(MAX_LEN), .ADDR_BYTES(ADDR_BYTES),
    .LEN_W(LEN_W), .IDX_W(IDX_W), .AW(AW)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start), .len_in(pay_len),
    .scr_in(scramble_en), .addr_in(tx_addr), .out_ready(out_ready),
    .busy(busy), .out_valid(out_valid), .hash_en(hash_en), .crc_clr(crc_clr),
    .len_q(len_q), .scr_q(scr_q), .addr_q(addr_q), .idx_q(idx_q),
    .frame_len(frame_len), .rd_idx(rd_idx)
  );

  rfenc_store #(.DEPTH(MAX_LEN), .AW(AW)) store_i (
    .clk(clk), .rst_n(rst_n), .lock(busy), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  assign white = rd_data ^ (scr_q ? white_key(4'(rd_idx)) : 8'h00);

  rfenc_crc crc_i (
    .clk(clk), .rst_n(rst_n), .clr(crc_clr), .en(hash_en),
    .din(white), .crc_q(crc_q)
  );

  rfenc_byte_map #(.ADDR_BYTES(ADDR_BYTES), .LEN_W(LEN_W), .IDX_W(IDX_W)) map_i (
    .idx(idx_q), .len_q(len_q), .addr_q(addr_q), .crc_q(crc_q),
    .scr_q(scr_q), .src_byte(white), .byte_out(out_data)
  );

  // R8: a stalled byte is held
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R8: a frame only ends on an accepted byte
  p_end_on_xfer_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(out_valid && out_ready));

endmodule

// File: tb/rfenc_top_tb_top.sv
module rfenc_top_tb_top;

  logic        clk, rst_n, start, scramble_en, wr_en, out_ready;
  logic [4:0]  pay_len;
  logic [31:0] tx_addr;
  logic [3:0]  wr_idx;
  logic [7:0]  wr_data, out_data;
  logic        busy, out_valid;
  logic [6:0]  frame_len;

  rfenc_top dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .pay_len(pay_len),
    .scramble_en(scramble_en), .tx_addr(tx_addr), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data), .busy(busy), .frame_len(frame_len),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  localparam logic [7:0] KEY [16] = '{8'hD0, 8'h9E, 8'h53, 8'h33, 8'hD8, 8'hBA,
    8'h98, 8'h08, 8'h24, 8'hCB, 8'h3B, 8'hFC, 8'h71, 8'hA3, 8'hF4, 8'h55};

  // {len, scramble, addr, seed, ready mode}
  localparam int NV = 6;
  localparam logic [47:0] VEC [NV] = '{
    {5'd14, 1'b0, 32'hA1B2C3D4, 8'h11, 2'd0},
    {5'd16, 1'b1, 32'h3C5A7E01, 8'h5A, 2'd1},
    {5'd0,  1'b0, 32'h00000001, 8'h00, 2'd2},
    {5'd1,  1'b1, 32'hF00F1234, 8'hE7, 2'd0},
    {5'd20, 1'b1, 32'h89ABCDEF, 8'h2C, 2'd1},
    {5'd7,  1'b0, 32'h0F1E2D3C, 8'h93, 2'd2}
  };

  logic [7:0] pay   [16];
  logic [7:0] ref_b [96];
  logic [7:0] got_b [96];
  int         ref_n;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] brev(input logic [7:0] b);
    return {b[0], b[1], b[2], b[3], b[4], b[5], b[6], b[7]};
  endfunction

  task automatic build_ref(input int n, input bit scr, input logic [31:0] a);
    logic [7:0]  s [18];
    logic [15:0] c;
    logic [7:0]  w, raw;
    logic        fb;
    c = 16'h0000;
    for (int i = 0; i < n; i++) begin
      w = pay[i] ^ (scr ? KEY[i] : 8'h00);
      s[i] = w;
      for (int j = 0; j < 8; j++) begin   // reversed byte MSB first == raw byte LSB first
        fb = c[15] ^ w[j];
        c  = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
      end
    end
    s[n]   = brev(c[15:8]) ^ (scr ? 8'hAE : 8'h00);
    s[n+1] = brev(c[7:0])  ^ (scr ? 8'hE4 : 8'h00);
    for (int i = 0; i < 4; i++) ref_b[i] = brev(a[8*i +: 8]);
    ref_b[4] = 8'hC3;
    ref_b[5] = 8'hC3;
    for (int i = 0; i < n + 2; i++)
      for (int qq = 0; qq < 4; qq++) begin
        raw[7:4] = s[i][2*qq]   ? 4'hC : 4'h3;
        raw[3:0] = s[i][2*qq+1] ? 4'hC : 4'h3;
        ref_b[6 + 4*i + qq] = brev(raw);
      end
    ref_n = 6 + 4 * (n + 2);
  endtask

  task automatic write_payload(input logic [7:0] seed);
    for (int i = 0; i < 16; i++) begin
      pay[i] = seed + 8'(i * 29);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 4'(i); wr_data = pay[i];
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_frame(input int len, input bit scr, input logic [31:0] a,
                           input int mode, input bit inject, input string tag);
    int  nc, got, cyc;
    bit  have_prev, hold_ok, rdy, injected;
    logic [7:0] prev;
    logic [31:0] fa [4];
    logic [31:0] fe [4];
    nc = (len > 16) ? 16 : len;
    build_ref(nc, scr, a);
    @(negedge clk);
    pay_len = 5'(len); scramble_en = scr; tx_addr = a; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({"R5 frame_len at start ", tag}, 32'(frame_len), 32'(ref_n));
    got = 0; cyc = 0; have_prev = 0; hold_ok = 1; injected = 0;
    while (got < ref_n && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      if (have_prev && (!out_valid || out_data !== prev)) hold_ok = 0;
      case (mode)
        0: rdy = 1'b1;
        1: rdy = cyc[0];
        default: rdy = (cyc % 3 == 0);
      endcase
      out_ready = rdy;
      if (inject && !injected && got == 3) begin
        start = 1'b1; pay_len = 5'd5; tx_addr = ~a;
        wr_en = 1'b1; wr_idx = 4'd0; wr_data = ~pay[0];
        injected = 1;
      end else begin
        start = 1'b0; wr_en = 1'b0;
      end
      if (out_valid && rdy) begin
        got_b[got] = out_data; got++; have_prev = 0;
      end else if (out_valid) begin
        have_prev = 1; prev = out_data;
      end else have_prev = 0;
    end
    @(negedge clk);
    out_ready = 1'b0; start = 1'b0; wr_en = 1'b0;
    chk({"R8 byte count ", tag}, 32'(got), 32'(ref_n));
    chk({"R8 valid low after frame ", tag}, {31'd0, out_valid}, 32'd0);
    chk({"R8 held while stalled ", tag}, {31'd0, hold_ok}, 32'd1);
    chk({"R9 frame_len kept ", tag}, 32'(frame_len), 32'(ref_n));
    for (int r = 0; r < 4; r++) begin fa[r] = 0; fe[r] = 0; end
    for (int i = 0; i < got && i < ref_n; i++) begin
      int r;
      r = (i < 4) ? 0 : (i < 6) ? 1 : (i < 6 + 4*nc) ? 2 : 3;
      if (got_b[i] !== ref_b[i] && fa[r] == fe[r]) begin
        fa[r] = {16'(i), 8'h00, got_b[i]};
        fe[r] = {16'(i), 8'h01, ref_b[i]};
      end
    end
    chk({"R7 address bytes reversed ", tag}, fa[0], fe[0]);
    chk({"R4 sync marker ", tag}, fa[1], fe[1]);
    if (scr) chk({"R1 whitened FEC payload ", tag}, fa[2], fe[2]);
    else     chk({"R6 FEC payload ", tag}, fa[2], fe[2]);
    if (scr) chk({"R3 masked CRC bytes ", tag}, fa[3], fe[3]);
    else     chk({"R2 CRC bytes ", tag}, fa[3], fe[3]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; scramble_en = 1'b0; wr_en = 1'b0;
    out_ready = 1'b0; pay_len = '0; tx_addr = '0; wr_idx = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 busy after reset", {31'd0, busy}, 32'd0);
    chk("R11 valid after reset", {31'd0, out_valid}, 32'd0);
    chk("R5 frame_len after reset", 32'(frame_len), 32'd14);

    for (int v = 0; v < NV; v++) begin
      write_payload(VEC[v][9:2]);
      run_frame(int'(VEC[v][47:43]), VEC[v][42], VEC[v][41:10],
                int'(VEC[v][1:0]), 1'b0, $sformatf("vec%0d", v));
    end

    // mid-frame start and payload write must both be ignored
    write_payload(8'h6D);
    run_frame(16, 1'b1, 32'h13579BDF, 1, 1'b1, "R9 R10 injected");
    // restart without rewriting: identical frame proves the write was dropped
    run_frame(16, 1'b1, 32'h13579BDF, 0, 1'b0, "R10 replay");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule